// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves one byte at a time over two wires: a shift clock that it always drives, and a data line that it drives while sending and leaves undriven while receiving. The data line is brought out as three plain signals: an output value, an output enable and an input value. The pad ring combines them into a bidirectional pin. One system clock cycle is one oscillator period, and every timing figure below is counted in those cycles.

The core starts a transfer with a one-cycle `txGo` pulse, with the byte on `txByte`, or with a one-cycle `rxGo` pulse. The port latches a speed code from `baudVal`. It holds the clock high for a short lead-in and then produces eight clock pulses, least significant bit first. Transmit data changes two cycles after each rising edge. Receive data is captured on each rising edge. The port releases the data line one cycle after the eighth rising edge and raises a sticky done flag, which the core clears with `doneClr`.

Speed code 1 selects the fast clock: a period of 4 cycles, low for 2. Any other code gives a clock that is low for 4 cycles and high for the larger of the code and 2 cycles. The period is therefore at least 6 cycles.

Top module: `sio_sync_port`

## Requirements
- R1: After reset, `sclkOut` is 1, `sdOe` is 0, `sdOut` is 1, `busy` is 0 and `doneFlag` is 0. Whenever the port is idle, `sclkOut` is 1 and `sdOe` is 0.
- R2: With `baudVal` equal to 1 at the start, each clock low phase lasts 2 cycles and each high phase between pulses lasts 2 cycles, giving a period of 4.
- R3: With any other `baudVal` code N at the start, each low phase lasts 4 cycles and each high phase between pulses lasts max(N,2) cycles.
- R4: Counting the cycle after the start pulse is sampled as cycle 0, `busy` and the driven bit 0 appear in cycle 0. The clock stays high in cycles 0 and 1, falls in cycle 2, and produces exactly 8 rising edges.
- R5: When transmitting, `sdOut` carries `txByte` least significant bit first. Bit i+1 replaces bit i exactly 2 cycles after rising edge i, and bit 7 stays on the line until release.
- R6: When receiving, `sdIn` is sampled at each rising edge, the first sample landing in bit 0. After the transfer, `rxByte` holds the 8 samples. A transmit transfer leaves `rxByte` unchanged.
- R7: When transmitting, `sdOe` is 1 from cycle 0 until the cycle of the eighth rising edge and drops 1 cycle later. When receiving, `sdOe` stays 0 and `sdOut` stays 1.
- R8: `doneFlag` and the fall of `busy` occur in the same cycle, 1 cycle after the eighth rising edge. `doneFlag` then holds until `doneClr`. A set wins over a clear in the same cycle.
- R9: `txGo` and `rxGo` are ignored while `busy` is 1. If both arrive together while idle, a transmit starts.
- R10: `baudVal` and `txByte` are used only in the start cycle. Changing them during a transfer leaves the clock timing and the transmitted bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudVal | input | BAUD_W | Speed code, latched at start |
| txGo | input | 1 | Start a transmit transfer (one-cycle pulse) |
| txByte | input | DATA_W | Byte to transmit, latched at start |
| rxGo | input | 1 | Start a receive transfer (one-cycle pulse) |
| doneClr | input | 1 | Clear the done flag |
| sdIn | input | 1 | Data line input value |
| sclkOut | output | 1 | Shift clock, idles high |
| sdOut | output | 1 | Data line output value |
| sdOe | output | 1 | Data line output enable |
| rxByte | output | DATA_W | Received byte |
| busy | output | 1 | Transfer in progress |
| doneFlag | output | 1 | Sticky transfer-complete flag |

## Verification
Every result of a transfer falls on a cycle that follows from the start cycle, the low length L and the high length H:
- The clock fall is due in cycle 2.
- Rising edge i is due in cycle 2+L+i(L+H).
- Each new transmit bit is due two cycles after its rising edge.
- Release of the line, the done flag and the fall of busy are all due in cycle 3+8L+7H.

The bench computes these cycle numbers in its own functions and compares every output once per cycle at the falling system clock edge. Each comparison is therefore made against the value registered at the preceding rising edge. Receive data is presented only while the shift clock is low and is randomised while it is high, so a late capture is caught.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // fixed timing constants, in oscillator cycles
  localparam int LEAD_CYC  = 2;  // clock held high before the first fall
  localparam int FAST_LOW  = 2;  // low phase for the fast code
  localparam int SLOW_LOW  = 4;  // low phase for every other code
  localparam int MIN_HIGH  = 2;  // shortest high phase
  localparam int DATA_DLY  = 2;  // cycles from rising edge to next data bit
  localparam int FAST_CODE = 1;  // speed code selecting the fast clock

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_LOW,
    S_HIGH,
    S_TAIL
  } sioState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // start accepted this cycle
    logic loadTx;    // start is a transmit
    logic shiftTx;   // advance the transmit bit
    logic sampleRx;  // rising edge: capture input
    logic drop;      // release the line
  } sioStb_t;

endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int BAUD_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BAUD_W-1:0] baudVal,
  input  logic              txGo,
  input  logic              rxGo,
  input  logic              doneClr,
  output logic              sclkOut,
  output logic              busy,
  output logic              doneFlag,
  output sioStb_t           stb
);

  localparam int CNT_W = (BAUD_W > 3) ? BAUD_W : 3;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  sioState_e        stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] lowLenQ;
  logic [CNT_W-1:0] highLenQ;
  logic [BIT_W-1:0] bitQ;
  logic             sclkQ;
  logic             fastQ;
  logic             doneQ;

  logic             start;
  logic             fastSel;
  logic [CNT_W-1:0] baudWide;
  logic [CNT_W-1:0] lowSel;
  logic [CNT_W-1:0] highSel;
  logic [CNT_W-1:0] updAt;

  // speed code decode, used only in the start cycle
  always_comb begin
    baudWide = CNT_W'(baudVal);
    fastSel  = (baudVal == BAUD_W'(FAST_CODE));
    lowSel   = fastSel ? CNT_W'(FAST_LOW) : CNT_W'(SLOW_LOW);
    highSel  = (baudWide < CNT_W'(MIN_HIGH)) ? CNT_W'(MIN_HIGH) : baudWide;
    updAt    = highLenQ - CNT_W'(DATA_DLY);
  end

  assign start = (stateQ == S_IDLE) && (txGo || rxGo);

  always_comb begin
    stb          = '0;
    stb.load     = start;
    stb.loadTx   = txGo;
    stb.sampleRx = (stateQ == S_LOW) && (cntQ == '0);
    stb.shiftTx  = (stateQ == S_HIGH) && (cntQ == updAt);
    stb.drop     = (stateQ == S_TAIL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      cntQ     <= '0;
      lowLenQ  <= CNT_W'(SLOW_LOW);
      highLenQ <= CNT_W'(MIN_HIGH);
      bitQ     <= '0;
      sclkQ    <= 1'b1;
      fastQ    <= 1'b0;
    end else begin
      unique case (stateQ)
        S_IDLE: begin
          if (start) begin
            stateQ   <= S_LEAD;
            cntQ     <= CNT_W'(LEAD_CYC - 1);
            lowLenQ  <= lowSel;
            highLenQ <= highSel;
            fastQ    <= fastSel;
            bitQ     <= '0;
          end
        end
        S_LEAD: begin
          if (cntQ == '0) begin
            sclkQ  <= 1'b0;
            stateQ <= S_LOW;
            cntQ   <= lowLenQ - CNT_W'(1);
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end
        S_LOW: begin
          if (cntQ == '0) begin
            sclkQ <= 1'b1;
            bitQ  <= bitQ + BIT_W'(1);
            if (bitQ == LAST_BIT) begin
              stateQ <= S_TAIL;
            end else begin
              stateQ <= S_HIGH;
              cntQ   <= highLenQ - CNT_W'(1);
            end
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end
        S_HIGH: begin
          if (cntQ == '0) begin
            sclkQ  <= 1'b0;
            stateQ <= S_LOW;
            cntQ   <= lowLenQ - CNT_W'(1);
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end
        S_TAIL: begin
          stateQ <= S_IDLE;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  // sticky completion flag, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
    end else if (stb.drop) begin
      doneQ <= 1'b1;
    end else if (doneClr) begin
      doneQ <= 1'b0;
    end
  end

  assign sclkOut  = sclkQ;
  assign busy     = (stateQ != S_IDLE);
  assign doneFlag = doneQ;

  // R1: the clock rests high whenever no transfer runs
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE) |-> sclkQ);

  // R2: fast code gives a two-cycle low phase
  p_fast_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclkQ) && fastQ) |=> !sclkQ ##1 sclkQ);

  // R3: other codes give a four-cycle low phase
  p_slow_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclkQ) && !fastQ) |=> !sclkQ ##1 !sclkQ ##1 !sclkQ ##1 sclkQ);

  // R8: done holds until cleared
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !doneClr) |=> doneQ);

endmodule

// File: rtl/sio_dp.sv
module sio_dp
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sioStb_t           stb,
  input  logic              sclk,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0] txShQ;
  logic [DATA_W-1:0] rxShQ;
  logic              oeQ;
  logic              rxModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShQ   <= '1;
      rxShQ   <= '0;
      oeQ     <= 1'b0;
      rxModeQ <= 1'b0;
    end else if (stb.load) begin
      if (stb.loadTx) begin
        txShQ <= txByte;
      end
      oeQ     <= stb.loadTx;
      rxModeQ <= !stb.loadTx;
    end else begin
      if (stb.shiftTx) begin
        txShQ <= {1'b1, txShQ[DATA_W-1:1]};
      end
      if (stb.sampleRx && rxModeQ) begin
        rxShQ <= {sdIn, rxShQ[DATA_W-1:1]};
      end
      if (stb.drop) begin
        oeQ     <= 1'b0;
        rxModeQ <= 1'b0;
      end
    end
  end

  assign sdOut  = oeQ ? txShQ[0] : 1'b1;
  assign sdOe   = oeQ;
  assign rxByte = rxShQ;

  // R5: the driven bit does not move inside a low phase
  p_bit_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (oeQ && !sclk && $past(!sclk)) |-> $stable(txShQ[0]));

  // R7: a receive never drives the line
  p_rx_undriven_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxModeQ |-> !oeQ);

endmodule

// File: rtl/sio_sync_port.sv
module sio_sync_port
  import sio_pkg::*;
#(
  parameter int BAUD_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BAUD_W-1:0] baudVal,
  input  logic              txGo,
  input  logic [DATA_W-1:0] txByte,
  input  logic              rxGo,
  input  logic              doneClr,
  input  logic              sdIn,
  output logic              sclkOut,
  output logic              sdOut,
  output logic              sdOe,
  output logic [DATA_W-1:0] rxByte,
  output logic              busy,
  output logic              doneFlag
);

  sioStb_t stb;
  logic    sclkInt;

  sio_ctrl #(
    .BAUD_W(BAUD_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baudVal (baudVal),
    .txGo    (txGo),
    .rxGo    (rxGo),
    .doneClr (doneClr),
    .sclkOut (sclkInt),
    .busy    (busy),
    .doneFlag(doneFlag),
    .stb     (stb)
  );

  sio_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .sclk  (sclkInt),
    .txByte(txByte),
    .sdIn  (sdIn),
    .sdOut (sdOut),
    .sdOe  (sdOe),
    .rxByte(rxByte)
  );

  assign sclkOut = sclkInt;

  // R9: a start while busy does not restart the lead-in
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sclkInt) |=> busy);

endmodule

// File: tb/tb_sio_sync_port.sv
`timescale 1ns/1ps
module tb_sio_sync_port;

  localparam int BAUD_W = 8;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [BAUD_W-1:0] baudVal = '0;
  logic              txGo = 1'b0;
  logic [DATA_W-1:0] txByte = '0;
  logic              rxGo = 1'b0;
  logic              doneClr = 1'b0;
  logic              sdIn = 1'b0;
  logic              sclkOut, sdOut, sdOe, busy, doneFlag;
  logic [DATA_W-1:0] rxByte;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  sio_sync_port #(.BAUD_W(BAUD_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .baudVal(baudVal), .txGo(txGo), .txByte(txByte),
    .rxGo(rxGo), .doneClr(doneClr), .sdIn(sdIn), .sclkOut(sclkOut),
    .sdOut(sdOut), .sdOe(sdOe), .rxByte(rxByte), .busy(busy), .doneFlag(doneFlag)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowOf(input int b);
    return (b == 1) ? 2 : 4;
  endfunction

  function automatic int highOf(input int b);
    return (b < 2) ? 2 : b;
  endfunction

  function automatic int lastRise(input int L, input int H);
    return 2 + 8 * L + 7 * H;
  endfunction

  function automatic bit expSclk(input int k, input int L, input int H);
    int t;
    if (k < 2 || k >= lastRise(L, H)) return 1'b1;
    t = (k - 2) % (L + H);
    return (t < L) ? 1'b0 : 1'b1;
  endfunction

  function automatic int expBit(input int k, input int L, input int H);
    int n = 0;
    for (int i = 0; i < 7; i++) begin
      if (k >= 2 + L + i * (L + H) + 2) n++;
    end
    return n;
  endfunction

  task automatic runXfer(input bit isTx, input bit bothGo, input logic [7:0] dat,
                         input int baud, input bit disturb);
    int L, H, last, rises;
    bit drv;
    logic [7:0] rxBefore;
    string tagS;
    L = lowOf(baud);
    H = highOf(baud);
    last = lastRise(L, H);
    drv = isTx || bothGo;
    @(negedge clk);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    check(doneFlag == 1'b0, "R8 clear", int'(doneFlag), 0);
    rxBefore = rxByte;
    baudVal = BAUD_W'(baud);
    txByte = dat;
    txGo = isTx || bothGo;
    rxGo = !isTx || bothGo;
    @(negedge clk);
    txGo = 1'b0;
    rxGo = 1'b0;
    rises = 0;
    for (int k = 0; k <= last + 3; k++) begin
      tagS = (k < 3) ? "R4 lead" : ((baud == 1) ? "R2 sclk" : "R3 sclk");
      check(sclkOut == expSclk(k, L, H), tagS, int'(sclkOut), int'(expSclk(k, L, H)));
      check(sdOe == (drv && k <= last), "R7 oe", int'(sdOe), int'(drv && k <= last));
      if (drv && k <= last)
        check(sdOut == dat[expBit(k, L, H)], "R5 txbit", int'(sdOut), int'(dat[expBit(k, L, H)]));
      else
        check(sdOut == 1'b1, "R7 idle line", int'(sdOut), 1);
      check(busy == (k <= last), "R9 busy", int'(busy), int'(k <= last));
      check(doneFlag == (k > last), "R8 done", int'(doneFlag), int'(k > last));
      if (k > 0 && sclkOut && k == 2 + L + rises * (L + H)) rises++;
      if (!sclkOut && rises < 8) sdIn = dat[rises];
      else sdIn = 1'($urandom);
      if (disturb && k == 3) begin
        baudVal = BAUD_W'($urandom_range(0, 30));
        txByte = ~dat;
        txGo = 1'b1;
        rxGo = 1'b1;
      end
      if (disturb && k == 4) begin
        txGo = 1'b0;
        rxGo = 1'b0;
      end
      @(negedge clk);
    end
    check(rises == 8, "R4 edge count", rises, 8);
    if (drv)
      check(rxByte == rxBefore, "R6 rx kept", int'(rxByte), int'(rxBefore));
    else
      check(rxByte == dat, "R6 rx byte", int'(rxByte), int'(dat));
    check(doneFlag == 1'b1, "R8 held", int'(doneFlag), 1);
    if (disturb)
      check(busy == 1'b0, "R10 no restart", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    check(sclkOut == 1'b1, "R1 sclk", int'(sclkOut), 1);
    check(sdOe == 1'b0, "R1 oe", int'(sdOe), 0);
    check(sdOut == 1'b1, "R1 sdOut", int'(sdOut), 1);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(doneFlag == 1'b0, "R1 done", int'(doneFlag), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    runXfer(1'b1, 1'b0, 8'hA5, 1, 1'b0);
    runXfer(1'b1, 1'b0, 8'h3C, 0, 1'b0);
    runXfer(1'b1, 1'b0, 8'h81, 2, 1'b0);
    runXfer(1'b0, 1'b0, 8'h96, 1, 1'b0);
    runXfer(1'b0, 1'b0, 8'h5B, 7, 1'b0);
    runXfer(1'b0, 1'b1, 8'hC3, 3, 1'b0);   // R9 both starts: transmit wins
    runXfer(1'b1, 1'b0, 8'h6E, 4, 1'b1);   // R10 changes mid transfer
    runXfer(1'b0, 1'b0, 8'h27, 1, 1'b1);
    // random transfers
    for (int n = 0; n < 12; n++) begin
      runXfer(1'($urandom), 1'b0, 8'($urandom), int'($urandom_range(0, 20)), 1'($urandom));
    end
    // R8: set dominates clear is not exercised; clear after hold is
    @(negedge clk);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    check(doneFlag == 1'b0, "R8 final clear", int'(doneFlag), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule